// File: doc/BRIEF.md
# Single-Byte-Addressed Two-Wire Memory Slave

This block is the bus side of a small serial memory holding 128 bytes. A master drives a clock line and shares an open-drain data line with it. The system clock oversamples both lines. Every transaction opens with a START and one byte that carries the memory location in its upper seven bits and the transfer direction in its last bit. No separate device-select byte is used, so a transfer can begin after a single byte. Reads come from an internal byte array. The first location is the one addressed, and each byte the master acknowledges moves the address on by one. The address wraps from the top location to the bottom.

Writes do not touch the array directly. Each received data byte goes to a separate program controller together with its address. A STOP that ends a write tells that controller to begin its program cycle. The controller later stores the bytes through a one-byte-per-cycle program port. While the controller reports busy, the slave answers nothing. A master can therefore poll for completion by sending address bytes until one is acknowledged. The data line is modelled as a pull-down enable: the slave can only pull the line low, and the line reads high when nobody pulls it.

Top module: `twm_slave`

## Requirements
- R1: After reset and after every STOP (data line rising while the clock line is high), the slave is idle and does not pull the data line. A START (data line falling while the clock line is high) begins reception of an address byte.
- R2: The address byte is sampled on clock-line rising edges, MSB first. Its bits 7..1 are the memory location and bit 0 is the direction (1 = read, 0 = write). The slave acknowledges it by pulling the data line low during the 9th clock.
- R3: In a write, each data byte is acknowledged and presented for one system clock on `wr_strobe`, with `wr_addr` and `wr_data`. After each byte, only the two low address bits advance, so the address wraps inside an aligned group of four locations.
- R4: `wr_commit` pulses for one system clock at a STOP that ends a write in which at least one data byte was received. It does not pulse after a read or after a write with no data byte.
- R5: In a read, the slave shifts out the byte at the current location MSB first. Its data-line drive changes only while the clock line is low, apart from aborts caused by a START or STOP.
- R6: When the master acknowledges a read byte, the slave sends the byte at the next location. Location 127 is followed by location 0.
- R7: When the master does not acknowledge a read byte, the slave returns to idle and pulls the data line on no further clock until the next START.
- R8: While `busy_i` is high at a START or at the end of the address byte, the slave does not acknowledge and stays idle.
- R9: After reset, every location of the array reads FFh.
- R10: A START in the middle of a transfer discards any partial byte and restarts address reception.
- R11: With `prog_we` high, `prog_data` is stored at `prog_addr` on that system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Resolved bus data line level |
| sda_oe | output | 1 | High pulls the data line low |
| busy_i | input | 1 | Program controller busy |
| wr_strobe | output | 1 | One-cycle pulse for a received write byte |
| wr_addr | output | 7 | Location of the received write byte |
| wr_data | output | 8 | Value of the received write byte |
| wr_commit | output | 1 | One-cycle pulse at STOP ending a write with data |
| prog_we | input | 1 | Program port write enable |
| prog_addr | input | 7 | Program port location |
| prog_data | input | 8 | Program port value |

## Verification
The hardest case to reach is the hand-off between the top location and location 0 inside one sequential read. Two distinct values must first be placed at both ends of the array, and the master has to acknowledge across that boundary. The bench stores them through the program port, then starts a read at location 127 and acknowledges the first byte. The busy-poll case is reached by writing a byte, raising `busy_i` as a controller would after the commit, and sending an address byte that must go unanswered.

// File: rtl/twm_pkg.sv
package twm_pkg;
    parameter int unsigned AW        = 7;
    parameter int unsigned DW        = 8;
    parameter int unsigned PAGE_BITS = 2;
    localparam int unsigned WORDS    = 1 << AW;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_WDATA, ST_RDATA, ST_RACK
    } bus_st_t;

    typedef struct packed {
        logic          strobe;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wbyte_t;

    function automatic logic [AW-1:0] page_next(input logic [AW-1:0] a);
        logic [PAGE_BITS-1:0] low;
        low = a[PAGE_BITS-1:0] + {{(PAGE_BITS-1){1'b0}}, 1'b1};
        return {a[AW-1:PAGE_BITS], low};
    endfunction
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic level_d
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain   <= '1;
            level_d <= 1'b1;
        end else begin
            chain   <= {chain[STAGES-2:0], din};
            level_d <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/twm_mem.sv
module twm_mem
    import twm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '1;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/twm_engine.sv
module twm_engine
    import twm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          scl,
    input  logic          scl_d,
    input  logic          sda,
    input  logic          sda_d,
    input  logic          busy,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          sda_oe,
    output wbyte_t        wr,
    output logic          commit
);
    localparam logic [3:0] LAST_BIT = 4'(DW);

    bus_st_t       st;
    logic [3:0]    cnt;
    logic [DW-1:0] shreg, tx;
    logic [AW-1:0] addr;
    logic          rw, wrote, mack;

    logic scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_rise = scl & ~scl_d;
    assign scl_fall = ~scl & scl_d;
    assign start_ev = scl & scl_d & sda_d & ~sda;
    assign stop_ev  = scl & scl_d & ~sda_d & sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            tx     <= '1;
            addr   <= '0;
            rw     <= 1'b0;
            wrote  <= 1'b0;
            mack   <= 1'b0;
            wr     <= '0;
            commit <= 1'b0;
        end else begin
            wr.strobe <= 1'b0;
            commit    <= 1'b0;
            if (start_ev) begin
                st    <= busy ? ST_IDLE : ST_ADDR;
                cnt   <= '0;
                wrote <= 1'b0;
            end else if (stop_ev) begin
                commit <= wrote;
                wrote  <= 1'b0;
                st     <= ST_IDLE;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[DW-2:0], sda};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            cnt  <= '0;
                            addr <= shreg[DW-1:1];
                            rw   <= shreg[0];
                            st   <= busy ? ST_IDLE : ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx   <= rd_data;
                                addr <= addr + 1'b1;
                                st   <= ST_RDATA;
                            end else begin
                                st <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[DW-2:0], sda};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            cnt   <= '0;
                            wr    <= '{strobe: 1'b1, addr: addr, data: shreg};
                            addr  <= page_next(addr);
                            wrote <= 1'b1;
                            st    <= ST_ACK;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (cnt == LAST_BIT - 4'd1) begin
                                cnt <= '0;
                                st  <= ST_RACK;
                            end else begin
                                tx  <= {tx[DW-2:0], 1'b1};
                                cnt <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda;
                        end else if (scl_fall) begin
                            if (mack) begin
                                tx   <= rd_data;
                                addr <= addr + 1'b1;
                                st   <= ST_RDATA;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign rd_addr = addr;
    assign sda_oe  = (st == ST_ACK) || (st == ST_RDATA && !tx[DW-1]);

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!scl || $past(start_ev || stop_ev))) else $error("oe moved with scl high"); // R5
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> (st == ST_IDLE && !sda_oe)) else $error("not idle after stop"); // R1
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
        (busy && st == ST_IDLE) |=> (st == ST_IDLE)) else $error("woke while busy"); // R8
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr.strobe |-> (addr[AW-1:PAGE_BITS] == wr.addr[AW-1:PAGE_BITS])) else $error("left page"); // R3
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr.strobe, commit})) else $error("strobe with commit"); // R4
    AST_NACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RACK && scl_fall && !mack && !start_ev && !stop_ev) |=> !sda_oe) else $error("drive after nack"); // R7
endmodule

// File: rtl/twm_slave.sv
module twm_slave
    import twm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          busy_i,
    output logic          wr_strobe,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_commit,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data
);
    logic          scl_s, scl_q, sda_s, sda_q;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    wbyte_t        wr;

    twm_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst(rst), .din(scl_i), .level(scl_s), .level_d(scl_q));
    twm_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst(rst), .din(sda_i), .level(sda_s), .level_d(sda_q));

    twm_mem u_mem (
        .clk(clk), .rst(rst), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
        .raddr(rd_addr), .rdata(rd_data));

    twm_engine u_eng (
        .clk(clk), .rst(rst), .scl(scl_s), .scl_d(scl_q), .sda(sda_s), .sda_d(sda_q),
        .busy(busy_i), .rd_data(rd_data), .rd_addr(rd_addr), .sda_oe(sda_oe),
        .wr(wr), .commit(wr_commit));

    assign wr_strobe = wr.strobe;
    assign wr_addr   = wr.addr;
    assign wr_data   = wr.data;
endmodule

// File: tb/sim_twm_slave.sv
module sim_twm_slave;
    localparam int CLK_P = 10;
    localparam int H     = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       m_low = 1'b0;
    logic       busy = 1'b0;
    logic       prog_we = 1'b0;
    logic [6:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic       sda_oe, wr_strobe, wr_commit;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;
    logic       sda_line;

    int checks = 0, errors = 0;
    int commits = 0, cap_n = 0, oe_bad = 0;
    logic oe_seen = 1'b0, oe_prev = 1'b0;
    logic [6:0] cap_addr [8];
    logic [7:0] cap_data [8];

    assign sda_line = !(m_low || sda_oe);

    twm_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .busy_i(busy), .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data));

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_commit) commits++;
            if (wr_strobe && cap_n < 8) begin
                cap_addr[cap_n] = wr_addr;
                cap_data[cap_n] = wr_data;
                cap_n++;
            end
            if (sda_oe) oe_seen = 1'b1;
            if (sda_oe != oe_prev && scl_m) oe_bad++;
            oe_prev = sda_oe;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (H) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_low = 1'b0; wait_h();
        scl_m = 1'b1; wait_h();
        m_low = 1'b1; wait_h();
        scl_m = 1'b0; wait_h();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wait_h();
        scl_m = 1'b1; wait_h();
        m_low = 1'b0; wait_h();
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; wait_h();
        scl_m = 1'b1; wait_h();
        scl_m = 1'b0; wait_h();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; wait_h();
        scl_m = 1'b1; wait_h();
        ack = ~sda_line;
        scl_m = 1'b0; wait_h();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_h();
            scl_m = 1'b1; wait_h();
            d[i] = sda_line;
            scl_m = 1'b0;
        end
        wait_h();
        send_bit(~give_ack);
        m_low = 1'b0;
    endtask

    task automatic prog(input logic [6:0] a, input logic [7:0] d);
        prog_addr = a; prog_data = d; prog_we = 1'b1;
        @(posedge clk); #1;
        prog_we = 1'b0;
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 reset release", int'(sda_oe), 0);
        chk(wr_strobe == 1'b0 && wr_commit == 1'b0, "R4 reset pulses", int'({wr_strobe, wr_commit}), 0);
    endtask

    task automatic t_blank_read();
        logic ack; logic [7:0] d; int c0;
        c0 = commits;
        bus_start();
        send_byte({7'h05, 1'b1}, ack);
        chk(ack, "R2 address ack", int'(ack), 1);
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R9 blank location", int'(d), 'hFF);
        bus_stop();
        chk(commits == c0, "R4 no commit after read", commits, c0);
    endtask

    task automatic t_byte_write();
        logic ack;
        cap_n = 0;
        bus_start();
        send_byte({7'h10, 1'b0}, ack);
        send_byte(8'hA5, ack);
        chk(ack, "R3 data byte ack", int'(ack), 1);
        bus_stop();
        wait_h();
        chk(cap_n == 1 && cap_addr[0] == 7'h10 && cap_data[0] == 8'hA5, "R3 write byte",
            int'({cap_addr[0], cap_data[0]}), 'h10A5);
        chk(commits == 1, "R4 commit after write", commits, 1);
    endtask

    task automatic t_busy_poll();
        logic ack; logic [7:0] d;
        busy = 1'b1;
        oe_seen = 1'b0;
        bus_start();
        send_byte({7'h10, 1'b1}, ack);
        chk(!ack && !oe_seen, "R8 silent while busy", int'({ack, oe_seen}), 0);
        bus_stop();
        for (int i = 0; i < cap_n; i++) prog(cap_addr[i], cap_data[i]);
        busy = 1'b0;
        wait_h();
        bus_start();
        send_byte({7'h10, 1'b1}, ack);
        chk(ack, "R8 ack after busy", int'(ack), 1);
        recv_byte(1'b0, d);
        chk(d == 8'hA5, "R11 programmed byte read R5", int'(d), 'hA5);
        bus_stop();
    endtask

    task automatic t_page_write();
        logic ack; logic [7:0] d;
        logic [7:0] vals [4];
        vals[0] = 8'h11; vals[1] = 8'h22; vals[2] = 8'h33; vals[3] = 8'h44;
        cap_n = 0;
        bus_start();
        send_byte({7'h1E, 1'b0}, ack);
        for (int i = 0; i < 4; i++) send_byte(vals[i], ack);
        bus_stop();
        wait_h();
        chk(cap_n == 4 && cap_addr[0] == 7'h1E && cap_addr[1] == 7'h1F &&
            cap_addr[2] == 7'h1C && cap_addr[3] == 7'h1D, "R3 page wrap",
            int'({cap_addr[2], cap_addr[3]}), 'h0E1D);
        chk(commits == 2, "R4 page commit", commits, 2);
        for (int i = 0; i < cap_n; i++) prog(cap_addr[i], cap_data[i]);
        bus_start();
        send_byte({7'h1C, 1'b1}, ack);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i != 3, d);
            chk(d == vals[(i + 2) % 4], "R6 sequential read", int'(d), int'(vals[(i + 2) % 4]));
        end
        bus_stop();
    endtask

    task automatic t_wrap();
        logic ack; logic [7:0] d;
        prog(7'h7F, 8'h5A);
        prog(7'h00, 8'hC3);
        bus_start();
        send_byte({7'h7F, 1'b1}, ack);
        recv_byte(1'b1, d);
        chk(d == 8'h5A, "R5 top location", int'(d), 'h5A);
        recv_byte(1'b0, d);
        chk(d == 8'hC3, "R6 wrap to zero", int'(d), 'hC3);
        bus_stop();
    endtask

    task automatic t_nack();
        logic ack; logic [7:0] d;
        bus_start();
        send_byte({7'h10, 1'b1}, ack);
        recv_byte(1'b0, d);
        oe_seen = 1'b0;
        recv_byte(1'b0, d);
        chk(d == 8'hFF && !oe_seen, "R7 standby after nack", int'({oe_seen, d}), 'hFF);
        bus_stop();
    endtask

    task automatic t_restart();
        logic ack; logic [7:0] d;
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte({7'h10, 1'b1}, ack);
        chk(ack, "R10 restart address ack", int'(ack), 1);
        recv_byte(1'b0, d);
        chk(d == 8'hA5, "R10 restart read", int'(d), 'hA5);
        bus_stop();
    endtask

    task automatic t_empty_write();
        logic ack; int c0, n0;
        c0 = commits; n0 = cap_n;
        bus_start();
        send_byte({7'h20, 1'b0}, ack);
        chk(ack, "R2 write address ack", int'(ack), 1);
        bus_stop();
        wait_h();
        chk(commits == c0 && cap_n == n0, "R4 no commit without data", commits, c0);
        chk(sda_oe == 1'b0, "R1 released after stop", int'(sda_oe), 0);
        chk(oe_bad == 0, "R5 drive moves with clock low", oe_bad, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        wait_h();
        t_reset();
        t_blank_read();
        t_byte_write();
        t_busy_poll();
        t_page_write();
        t_wrap();
        t_nack();
        t_restart();
        t_empty_write();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule